// File: doc/BRIEF.md
# Self-checking ECC encode and correct pipeline

This block is the error-correction datapath that sits between a memory array and its users. On the write side, a 7-bit data word is turned into a 15-bit codeword of a one-step majority-decodable cyclic code. On the read side, a 15-bit word fetched from memory is repaired by a majority-vote corrector, and its 7 data bits are returned. Both computing units are watched by their own syndrome checker. Each check bit of that checker is formed by a separate XOR cone, so one upset inside the checker can spoil at most one check bit.

When a checker finds that the result just computed by its unit is not a codeword, the unit computes the result again from the input it has kept, and the port stalls for that time. This is bounded to three re-executions. If the result is still wrong after the last one, the word is delivered marked bad and a sticky flag for that port is raised. Each delivered word carries its retry count. On the read side, one flag reports that the corrector repaired a memory error, and a separate flag reports that the checker caught a fault in the logic. Two fault-mask inputs XOR a pattern onto each unit's freshly computed result. They stand in for transient upsets inside the encoder and corrector logic.

Top module: `fs_ecc_pipe`

## Requirements
- R1: A written data word d appears as codeword bits [14:8] = d and bits [7:0] = remainder of x^8·d(x) divided by g(x) = 1 + x^4 + x^6 + x^7 + x^8, where bit j holds the coefficient of x^j and data bit 6 is the highest term.
- R2: Every codeword delivered unmarked on either port satisfies all fifteen checks c[m] ^ c[m-4] ^ c[m-6] ^ c[m-7] = 0, with indices taken modulo 15.
- R3: A read word with at most two flipped bits relative to a codeword returns that codeword's data bits on rd_data.
- R4: rd_mem_fixed is 1 exactly when the corrector changed at least one bit of the received word, and 0 for a clean read.
- R5: With no logic fault, a word accepted at clock edge k is delivered after edge k+1, and each port accepts one word on every clock edge.
- R6: If the checker flags a freshly computed result, the unit recomputes it from the word it holds. The delivered retry count equals the number of failed attempts (up to three), and rd_logic_fault is 1 exactly when that count is non-zero.
- R7: While a recomputation is pending, the port's ready output is 0, and a word offered in that cycle is not taken.
- R8: If the fourth attempt still fails the check, the word is delivered with its bad flag set and a retry count of 3. The port's sticky uncorrectable flag rises and stays set until reset.
- R9: During and just after reset, both ready outputs are 1, no output valid is set and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write data offered |
| wr_ready | output | 1 | Write data accepted on this edge when high |
| wr_data | input | 7 | Information word to encode |
| wr_fault_mask | input | 15 | XOR pattern applied to each encoder result computed at this edge |
| wr_cw_valid | output | 1 | Encoded word delivered this cycle |
| wr_cw | output | 15 | Encoded codeword |
| wr_cw_bad | output | 1 | Delivered codeword failed every attempt |
| wr_retries | output | 2 | Number of encoder recomputations for this word |
| wr_uncorr | output | 1 | Sticky: some write word was delivered bad |
| rd_valid | input | 1 | Read codeword offered |
| rd_ready | output | 1 | Read codeword accepted on this edge when high |
| rd_cw | input | 15 | Codeword read from memory |
| rd_fault_mask | input | 15 | XOR pattern applied to each corrector result computed at this edge |
| rd_out_valid | output | 1 | Corrected word delivered this cycle |
| rd_data | output | 7 | Corrected information bits |
| rd_bad | output | 1 | Corrected word failed every attempt |
| rd_mem_fixed | output | 1 | Corrector flipped at least one received bit |
| rd_logic_fault | output | 1 | Checker caught a fault in the corrector result for this word |
| rd_retries | output | 2 | Number of corrector recomputations for this word |
| rd_uncorr | output | 1 | Sticky: some read word was delivered bad |

## Verification
The bench builds the block with its default retry limit of three. That makes every retry count from zero to three reachable, and so is the give-up case, by holding a fault mask over one, two, three or five consecutive computations. Streams of back-to-back words check the one-cycle latency and full throughput. The read stream mixes clean words with one- and two-bit memory errors, and the result is compared with a nearest-codeword search in the bench. A word offered while a recomputation is pending checks that the stall really refuses input.

// File: rtl/fs_ecc_pkg.sv
package fs_ecc_pkg;
  localparam int CW_N   = 15;
  localparam int INFO_K = 7;
  localparam int PAR_W  = CW_N - INFO_K;
  // generator without its leading x^8 term: x^7 + x^6 + x^4 + 1
  localparam logic [PAR_W-1:0] GEN_LOW = 8'b1101_0001;

  // one parity check: bits m, m-4, m-6, m-7 (mod 15)
  function automatic logic check_sum(input logic [CW_N-1:0] c, input int m);
    logic [CW_N-1:0] sel;
    sel = (CW_N'(1) << m) | (CW_N'(1) << ((m + 11) % CW_N))
        | (CW_N'(1) << ((m + 9) % CW_N)) | (CW_N'(1) << ((m + 8) % CW_N));
    return ^(c & sel);
  endfunction

  // systematic encoder: data on top, remainder of x^8 d(x) / g(x) below
  function automatic logic [CW_N-1:0] encode_info(input logic [INFO_K-1:0] d);
    logic [PAR_W-1:0]  r;
    logic [INFO_K-1:0] s;
    logic              fb;
    r = '0;
    s = d;
    for (int b = 0; b < INFO_K; b++) begin
      fb = s[INFO_K-1] ^ r[PAR_W-1];
      s  = s << 1;
      r  = r << 1;
      if (fb) r = r ^ GEN_LOW;
    end
    return {d, r};
  endfunction

  // one-step majority vote over the four checks orthogonal on each bit
  function automatic logic [CW_N-1:0] correct_word(input logic [CW_N-1:0] c);
    logic [CW_N-1:0] flip;
    int cnt;
    flip = '0;
    for (int i = 0; i < CW_N; i++) begin
      cnt = int'(check_sum(c, i)) + int'(check_sum(c, (i + 4) % CW_N))
          + int'(check_sum(c, (i + 6) % CW_N)) + int'(check_sum(c, (i + 7) % CW_N));
      if (cnt >= 3) flip = flip | (CW_N'(1) << i);
    end
    return c ^ flip;
  endfunction
endpackage

// File: rtl/fs_syndrome_det.sv
module fs_syndrome_det #(
  parameter int N = fs_ecc_pkg::CW_N
) (
  input  logic [N-1:0] cw,
  output logic         err
);
  logic [N-1:0] syn;

  // separate XOR cone per check bit, nothing shared between them
  for (genvar m = 0; m < N; m++) begin : g_chk
    assign syn[m] = cw[m] ^ cw[(m + N - 4) % N] ^ cw[(m + N - 6) % N] ^ cw[(m + N - 7) % N];
  end

  assign err = |syn;
endmodule

// File: rtl/fs_retry_stage.sv
module fs_retry_stage #(
  parameter int N         = fs_ecc_pkg::CW_N,
  parameter int K         = fs_ecc_pkg::INFO_K,
  parameter int IW        = K,
  parameter int OW        = N,
  parameter int MAX_RETRY = 3,
  parameter bit CORRECT   = 1'b0,
  localparam int TW       = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_word,
  input  logic [N-1:0]  flip,
  output logic          out_valid,
  output logic [OW-1:0] out_word,
  output logic          out_bad,
  output logic [TW-1:0] out_tries,
  output logic          out_fixed,
  output logic          out_uncorr
);
  logic [IW-1:0] src_q, calc_src;
  logic [N-1:0]  cw_q, calc_cw;
  logic          v_q, fix_q, calc_fix, det_err, retry, finish;
  logic [TW-1:0] tries_q;

  fs_syndrome_det #(.N(N)) det_i (.cw(cw_q), .err(det_err));

  assign retry    = v_q & det_err & (tries_q != TW'(MAX_RETRY));
  assign finish   = v_q & ~retry;
  assign in_ready = ~retry;
  assign calc_src = retry ? src_q : in_word;

  if (CORRECT) begin : g_corrector
    always_comb begin
      calc_cw  = fs_ecc_pkg::correct_word(calc_src);
      calc_fix = (calc_cw != calc_src);
    end
  end else begin : g_encoder
    always_comb begin
      calc_cw  = fs_ecc_pkg::encode_info(calc_src);
      calc_fix = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q        <= 1'b0;
      src_q      <= '0;
      cw_q       <= '0;
      fix_q      <= 1'b0;
      tries_q    <= '0;
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_bad    <= 1'b0;
      out_tries  <= '0;
      out_fixed  <= 1'b0;
      out_uncorr <= 1'b0;
    end else begin
      out_valid <= finish;
      if (finish) begin
        out_word  <= cw_q[N-1 -: OW];
        out_bad   <= det_err;
        out_tries <= tries_q;
        out_fixed <= fix_q;
        if (det_err) out_uncorr <= 1'b1;
      end
      if (retry) begin
        cw_q    <= calc_cw ^ flip;
        fix_q   <= calc_fix;
        tries_q <= tries_q + 1'b1;
      end else if (in_valid) begin
        src_q   <= in_word;
        cw_q    <= calc_cw ^ flip;
        fix_q   <= calc_fix;
        tries_q <= '0;
        v_q     <= 1'b1;
      end else begin
        v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fs_ecc_pipe.sv
module fs_ecc_pipe #(
  parameter int MAX_RETRY = 3,
  localparam int N  = fs_ecc_pkg::CW_N,
  localparam int K  = fs_ecc_pkg::INFO_K,
  localparam int TW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [K-1:0]  wr_data,
  input  logic [N-1:0]  wr_fault_mask,
  output logic          wr_cw_valid,
  output logic [N-1:0]  wr_cw,
  output logic          wr_cw_bad,
  output logic [TW-1:0] wr_retries,
  output logic          wr_uncorr,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [N-1:0]  rd_cw,
  input  logic [N-1:0]  rd_fault_mask,
  output logic          rd_out_valid,
  output logic [K-1:0]  rd_data,
  output logic          rd_bad,
  output logic          rd_mem_fixed,
  output logic          rd_logic_fault,
  output logic [TW-1:0] rd_retries,
  output logic          rd_uncorr
);
  logic wr_fixed_nc;

  fs_retry_stage #(
    .N(N), .K(K), .IW(K), .OW(N), .MAX_RETRY(MAX_RETRY), .CORRECT(1'b0)
  ) enc_i (
    .clk(clk), .rst(rst),
    .in_valid(wr_valid), .in_ready(wr_ready), .in_word(wr_data), .flip(wr_fault_mask),
    .out_valid(wr_cw_valid), .out_word(wr_cw), .out_bad(wr_cw_bad),
    .out_tries(wr_retries), .out_fixed(wr_fixed_nc), .out_uncorr(wr_uncorr)
  );

  fs_retry_stage #(
    .N(N), .K(K), .IW(N), .OW(K), .MAX_RETRY(MAX_RETRY), .CORRECT(1'b1)
  ) cor_i (
    .clk(clk), .rst(rst),
    .in_valid(rd_valid), .in_ready(rd_ready), .in_word(rd_cw), .flip(rd_fault_mask),
    .out_valid(rd_out_valid), .out_word(rd_data), .out_bad(rd_bad),
    .out_tries(rd_retries), .out_fixed(rd_mem_fixed), .out_uncorr(rd_uncorr)
  );

  assign rd_logic_fault = |rd_retries;
endmodule

// File: rtl/fs_ecc_pipe_chk.sv
module fs_ecc_pipe_chk #(
  parameter int MAX_RETRY = 3,
  localparam int N  = fs_ecc_pkg::CW_N,
  localparam int TW = $clog2(MAX_RETRY + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_ready,
  input logic          wr_cw_valid,
  input logic [N-1:0]  wr_cw,
  input logic          wr_cw_bad,
  input logic [TW-1:0] wr_retries,
  input logic          wr_uncorr,
  input logic          rd_ready,
  input logic          rd_out_valid,
  input logic          rd_bad,
  input logic [TW-1:0] rd_retries,
  input logic          rd_uncorr,
  input logic          rd_logic_fault
);
  function automatic logic all_checks_zero(input logic [N-1:0] c);
    logic any;
    any = 1'b0;
    for (int m = 0; m < N; m++) any = any | fs_ecc_pkg::check_sum(c, m);
    return !any;
  endfunction

  p_clean_codeword_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_cw_valid && !wr_cw_bad) |-> all_checks_zero(wr_cw));

  p_wr_bad_at_limit_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_cw_valid && wr_cw_bad) |-> (wr_retries == TW'(MAX_RETRY)));

  p_rd_bad_at_limit_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_out_valid && rd_bad) |-> (rd_retries == TW'(MAX_RETRY)));

  p_wr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    wr_uncorr |=> wr_uncorr);

  p_rd_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rd_uncorr |=> rd_uncorr);

  p_wr_stall_no_out_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |=> !wr_cw_valid);

  p_rd_stall_no_out_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_ready |=> !rd_out_valid);

  p_logic_fault_stalled_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_out_valid && rd_logic_fault) |-> !$past(rd_ready, 2));

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!wr_cw_valid && !rd_out_valid && !wr_uncorr && !rd_uncorr));
endmodule

bind fs_ecc_pipe fs_ecc_pipe_chk #(.MAX_RETRY(MAX_RETRY)) chk_i (.*);

// File: tb/fs_ecc_pipe_tb_top.sv
`timescale 1ns/1ps
module fs_ecc_pipe_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        wr_valid = 1'b0, wr_ready;
  logic [6:0]  wr_data = '0;
  logic [14:0] wr_fault_mask = '0;
  logic        wr_cw_valid, wr_cw_bad, wr_uncorr;
  logic [14:0] wr_cw;
  logic [1:0]  wr_retries;
  logic        rd_valid = 1'b0, rd_ready;
  logic [14:0] rd_cw = '0, rd_fault_mask = '0;
  logic        rd_out_valid, rd_bad, rd_mem_fixed, rd_logic_fault, rd_uncorr;
  logic [6:0]  rd_data;
  logic [1:0]  rd_retries;

  fs_ecc_pipe dut_i (.*);

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [14:0] v;
    logic        bad;
    int          tries;
    logic        fixed;
  } exp_t;
  exp_t wq[$], rq[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference: long division by g = 0x1D1
  function automatic logic [14:0] ref_enc(input logic [6:0] d);
    logic [14:0] v;
    v = {d, 8'h00};
    for (int b = 14; b >= 8; b--)
      if (v[b]) v = v ^ (15'h01D1 << (b - 8));
    return {d, v[7:0]};
  endfunction

  // reference: nearest codeword within distance two, by search
  function automatic int ref_dec(input logic [14:0] r);
    for (int d = 0; d < 128; d++)
      if ($countones(ref_enc(7'(d)) ^ r) <= 2) return d;
    return -1;
  endfunction

  function automatic bit checks_ok(input logic [14:0] c);
    for (int m = 0; m < 15; m++)
      if (c[m] ^ c[(m + 11) % 15] ^ c[(m + 9) % 15] ^ c[(m + 8) % 15]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int lim3(input int m);
    return (m > 3) ? 3 : m;
  endfunction

  // per-clock comparison against the expected queues
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_cw_valid) begin
        if (wq.size() == 0) chk(1'b0, "R5", "unexpected write output", int'(wr_cw), 0);
        else begin
          exp_t e;
          e = wq.pop_front();
          chk(cyc == e.at, "R5", "write output cycle", cyc, e.at);
          chk(wr_cw_bad == e.bad, "R8", "write bad flag", int'(wr_cw_bad), int'(e.bad));
          chk(int'(wr_retries) == e.tries, "R6", "write retries", int'(wr_retries), e.tries);
          if (!e.bad) begin
            chk(wr_cw == e.v, "R1", "codeword", int'(wr_cw), int'(e.v));
            chk(checks_ok(wr_cw), "R2", "checks on codeword", int'(wr_cw), 0);
          end
        end
      end
      if (rd_out_valid) begin
        if (rq.size() == 0) chk(1'b0, "R5", "unexpected read output", int'(rd_data), 0);
        else begin
          exp_t e;
          e = rq.pop_front();
          chk(cyc == e.at, "R5", "read output cycle", cyc, e.at);
          chk(rd_bad == e.bad, "R8", "read bad flag", int'(rd_bad), int'(e.bad));
          chk(int'(rd_retries) == e.tries, "R6", "read retries", int'(rd_retries), e.tries);
          chk(rd_logic_fault == (e.tries > 0), "R6", "logic fault flag", int'(rd_logic_fault), int'(e.tries > 0));
          if (!e.bad) begin
            chk(rd_data == e.v[6:0], "R3", "corrected data", int'(rd_data), int'(e.v[6:0]));
            chk(rd_mem_fixed == e.fixed, "R4", "memory fix flag", int'(rd_mem_fixed), int'(e.fixed));
          end
        end
      end
    end
  end

  // one write word whose encoder result is upset on m consecutive computations
  task automatic wr_word(input logic [6:0] d, input logic [14:0] mask, input int m);
    exp_t e;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R7", "write ready before offer", int'(wr_ready), 1);
    wr_valid = 1'b1;
    wr_data = d;
    wr_fault_mask = (m > 0) ? mask : '0;
    e.at = cyc + 2 + lim3(m);
    e.v = ref_enc(d);
    e.bad = (m >= 4);
    e.tries = lim3(m);
    e.fixed = 1'b0;
    wq.push_back(e);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int j = 1; j < m; j++) @(negedge clk);
    wr_fault_mask = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd_word(input logic [14:0] cw, input logic [14:0] mask, input int m, input bit distract);
    exp_t e;
    int dd;
    @(negedge clk);
    chk(rd_ready == 1'b1, "R7", "read ready before offer", int'(rd_ready), 1);
    rd_valid = 1'b1;
    rd_cw = cw;
    rd_fault_mask = (m > 0) ? mask : '0;
    dd = ref_dec(cw);
    e.at = cyc + 2 + lim3(m);
    e.v = {8'h00, 7'(dd)};
    e.bad = (m >= 4);
    e.tries = lim3(m);
    e.fixed = (cw != ref_enc(7'(dd)));
    rq.push_back(e);
    @(negedge clk);
    if (distract) begin
      chk(rd_ready == 1'b0, "R7", "read ready during retry", int'(rd_ready), 0);
      rd_cw = ~cw;
    end else begin
      rd_valid = 1'b0;
    end
    for (int j = 1; j < m; j++) begin
      @(negedge clk);
      rd_valid = 1'b0;
    end
    rd_valid = 1'b0;
    rd_fault_mask = '0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet state out of reset
    chk(wr_ready == 1'b1, "R9", "wr_ready after reset", int'(wr_ready), 1);
    chk(rd_ready == 1'b1, "R9", "rd_ready after reset", int'(rd_ready), 1);
    chk(!wr_cw_valid && !rd_out_valid, "R9", "valids after reset", int'({wr_cw_valid, rd_out_valid}), 0);
    chk(!wr_uncorr && !rd_uncorr, "R9", "sticky flags after reset", int'({wr_uncorr, rd_uncorr}), 0);

    // R1 R2 R5: back-to-back writes, including both extremes
    for (int i = 0; i < 24; i++) begin
      exp_t e;
      logic [6:0] d;
      d = (i == 0) ? 7'h00 : (i == 1) ? 7'h7F : 7'((i * 37 + 5) % 128);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data = d;
      e.at = cyc + 2; e.v = ref_enc(d); e.bad = 1'b0; e.tries = 0; e.fixed = 1'b0;
      wq.push_back(e);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (5) @(negedge clk);

    // R3 R4 R5: back-to-back reads with zero, one and two memory errors
    for (int i = 0; i < 30; i++) begin
      exp_t e;
      logic [6:0]  d;
      logic [14:0] err;
      d = 7'((i * 53 + 11) % 128);
      err = (i % 3 == 0) ? 15'h0000 :
            (i % 3 == 1) ? (15'h0001 << (i % 15)) :
                           ((15'h0001 << (i % 15)) | (15'h0001 << ((i + 5) % 15)));
      @(negedge clk);
      rd_valid = 1'b1;
      rd_cw = ref_enc(d) ^ err;
      e.at = cyc + 2; e.v = {8'h00, d}; e.bad = 1'b0; e.tries = 0; e.fixed = (err != 0);
      rq.push_back(e);
    end
    @(negedge clk);
    rd_valid = 1'b0;
    repeat (5) @(negedge clk);

    // R6: encoder upsets that a retry clears
    wr_word(7'h2A, 15'h0100, 1);
    wr_word(7'h55, 15'h0004, 2);
    wr_word(7'h13, 15'h4000, 3);
    chk(wr_uncorr == 1'b0, "R8", "write sticky before give-up", int'(wr_uncorr), 0);
    // R8: encoder upset on every attempt
    wr_word(7'h66, 15'h0020, 5);
    chk(wr_uncorr == 1'b1, "R8", "write sticky after give-up", int'(wr_uncorr), 1);

    // R6 R7: corrector upsets, one offered word during the stall
    rd_word(ref_enc(7'h31) ^ 15'h0010, 15'h0002, 1, 1'b0);
    rd_word(ref_enc(7'h4C), 15'h0800, 2, 1'b1);
    rd_word(ref_enc(7'h07) ^ 15'h0081, 15'h0040, 3, 1'b0);
    chk(rd_uncorr == 1'b0, "R8", "read sticky before give-up", int'(rd_uncorr), 0);
    // R8: corrector upset on every attempt, then a clean word
    rd_word(ref_enc(7'h5A), 15'h2000, 5, 1'b0);
    chk(rd_uncorr == 1'b1, "R8", "read sticky after give-up", int'(rd_uncorr), 1);
    rd_word(ref_enc(7'h19), 15'h0000, 0, 1'b0);
    chk(rd_uncorr == 1'b1 && wr_uncorr == 1'b1, "R8", "sticky flags held", int'({wr_uncorr, rd_uncorr}), 3);

    chk(wq.size() == 0 && rq.size() == 0, "R5", "words still owed", wq.size() + rq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #750000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule